// File: doc/BRIEF.md
# I2C Target Engine with Software Stall Handshake

This block is the target (slave) side of an I2C bus. It watches SCL and SDA and finds START and STOP conditions. It shifts in the address byte and compares its upper seven bits with a programmable own address. It then either receives bytes from the host or sends bytes to it.

Each address match, each STOP that ends an addressed transfer and each completed byte raises an event flag. While a flag is pending and stalling is enabled, the engine holds SCL low after the acknowledge clock. Software answers with one command word, which clears the events. The same word sets the ACK choice for the next received byte, or supplies the next byte to transmit.

The engine runs as a single state machine with these states:
- `S_IDLE`: waits for a START.
- `S_ADDR`: shifts in the address.
- `S_ADDR_ACK`: drives the address acknowledge.
- `S_STALL`: holds SCL low until the handshake is answered.
- `S_RX`: shifts in a byte from the host.
- `S_RX_ACK`: drives the ACK or NACK for that byte.
- `S_TX`: shifts out a byte to the host.
- `S_TX_ACK`: samples the host acknowledge.
- `S_WAIT`: ignores the bus until the next START or STOP.

The transitions are:
- IDLE→ADDR on START.
- ADDR→ADDR_ACK on a match at the falling edge after the eighth bit.
- ADDR→WAIT on a mismatch at that edge.
- ADDR_ACK→STALL, RX_ACK→STALL and TX_ACK→STALL (after a host ACK) at the falling edge that ends the acknowledge clock.
- STALL→TX or STALL→RX once no event is pending, or stalling is off.
- RX→RX_ACK after eight bits.
- TX→TX_ACK after eight bits.
- TX_ACK→WAIT after a host NACK.
- Any state→ADDR on START.
- Any state→IDLE on STOP.

Top module: `i2c_target_stall`

## Requirements
- R1: After reset, neither SCL nor SDA is pulled low, both event flags are clear, all status bits are 0 and the received byte reads 0.
- R2: When the address byte's upper seven bits equal `own_addr[7:1]`, the target pulls SDA low during the ninth clock. It also sets `evt_cmd`, with `stat_read` equal to the R/W bit (bit 0 of the address byte, 1 = host reads) and `stat_stop` = 0.
- R3: If `own_addr` is 0, or the address differs, the target leaves SDA released on the ninth clock and raises no event, either then or on the following STOP.
- R4: Suppose the stall bit (bit 0 of the command word) is set and an event is still pending at the falling edge that ends an acknowledge clock. Then the target holds SCL low until a command word with the clear bit (bit 6) set is written.
- R5: A byte written by the host appears on `rx_byte` MSB first. It comes with `evt_data` set and `stat_read` = 0.
- R6: A received byte is ACKed if the ACK-enable bit (bit 3) of the most recent command word was 1 when the byte completed. Otherwise it is NACKed (SDA left high).
- R7: In a read, the byte the target sends is bits [15:8] of the command word written with the clear bit, sent MSB first.
- R8: After each transmitted byte, `evt_data` is set with `stat_read` = 1 and `stat_ack` equal to the host acknowledge (1 = ACK). After a NACK, the target releases SDA and does not stretch SCL.
- R9: A STOP after the target was addressed sets `evt_cmd` with `stat_stop` = 1 and `stat_read` = 0.
- R10: A repeated START in the middle of a byte drops that byte with no data event and starts a new address phase.
- R11: With the stall bit clear, the target never stretches SCL, even while events are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low (stretch) |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| own_addr | input | 8 | Own 7-bit address in bits [7:1]; 0 disables matching |
| cmd_wr | input | 1 | One-cycle strobe that writes `cmd_word` |
| cmd_word | input | 16 | Bit 0 stall enable, bit 3 ACK enable, bit 6 clear events, [15:8] next transmit byte |
| evt_cmd | output | 1 | Address-match or STOP event pending |
| evt_data | output | 1 | Completed-byte event pending |
| stat_stop | output | 1 | Last event was a STOP |
| stat_read | output | 1 | Host is reading |
| stat_ack | output | 1 | Host ACKed the last transmitted byte |
| rx_byte | output | 8 | Last byte received from the host |

## Verification
The bench runs a host model with clock-stretch support against a software responder. The responder answers every event after a fixed delay, and a scoreboard compares each event's kind and status against what the host sequence predicts.

- A write whose ACK-enable bit changes between bytes tells a correctly latched ACK decision from a stale or early one.
- A read ending in a host NACK separates the continue path from the end-of-read path.
- Wrong and zero own addresses show that matching is gated.
- A repeated START inside a byte shows the partial byte is dropped and no data event appears.
- Measuring stretch length with stalling on and then off tells the handshake apart from free-running operation.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
    localparam int BYTE_W      = 8;
    localparam int CMD_W       = 16;
    localparam int CMD_STALL   = 0;
    localparam int CMD_ACK     = 3;
    localparam int CMD_CLR     = 6;
    localparam int CMD_TXD_LSB = 8;
    localparam int CNT_W       = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_ADDR_ACK, S_STALL,
        S_RX, S_RX_ACK, S_TX, S_TX_ACK, S_WAIT
    } tgt_state_e;
endpackage

// File: rtl/i2ct_line_sync.sv
module i2ct_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_d, sda_d, scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2ct_evt_regs.sv
module i2ct_evt_regs
    import i2ct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              ev_cmd,
    input  logic              ev_data,
    input  logic              ev_stop,
    input  logic              ev_read,
    input  logic              ev_ack,
    input  logic [BYTE_W-1:0] ev_rx,
    output logic              stall_en,
    output logic              ack_en,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              evt_cmd,
    output logic              evt_data,
    output logic              stat_stop,
    output logic              stat_read,
    output logic              stat_ack,
    output logic [BYTE_W-1:0] rx_byte
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stall_en  <= 1'b0;
            ack_en    <= 1'b0;
            tx_byte   <= '0;
            evt_cmd   <= 1'b0;
            evt_data  <= 1'b0;
            stat_stop <= 1'b0;
            stat_read <= 1'b0;
            stat_ack  <= 1'b0;
            rx_byte   <= '0;
        end else begin
            if (cmd_wr) begin
                stall_en <= cmd_word[CMD_STALL];
                ack_en   <= cmd_word[CMD_ACK];
                if (cmd_word[CMD_CLR]) begin
                    evt_cmd  <= 1'b0;
                    evt_data <= 1'b0;
                    tx_byte  <= cmd_word[CMD_TXD_LSB +: BYTE_W];
                end
            end
            if (ev_cmd) begin
                evt_cmd   <= 1'b1;
                stat_stop <= ev_stop;
                stat_read <= ev_read;
                stat_ack  <= 1'b0;
            end
            if (ev_data) begin
                evt_data  <= 1'b1;
                stat_stop <= 1'b0;
                stat_read <= ev_read;
                stat_ack  <= ev_ack;
                if (!ev_read) rx_byte <= ev_rx;
            end
        end
    end

    // R2/R5: an address event and a byte event never arrive together
    assert_single_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_cmd, ev_data}));
endmodule

// File: rtl/i2ct_fsm.sv
module i2ct_fsm
    import i2ct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    input  logic [BYTE_W-1:0] own_addr,
    input  logic              evt_pend,
    input  logic              stall_en,
    input  logic              ack_en,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              ev_cmd,
    output logic              ev_data,
    output logic              ev_stop,
    output logic              ev_read,
    output logic              ev_ack,
    output logic [BYTE_W-1:0] ev_rx
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] TX_LAST  = CNT_W'(BYTE_W - 1);

    tgt_state_e        state, nxt;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic              sda_q, dir_rd, active, host_ack;
    logic              addr_hit, go, done_addr, rx_done, tx_acked, quiet;

    always_comb begin
        quiet     = !start_det && !stop_det;
        addr_hit  = (own_addr != '0) && (shreg[BYTE_W-1:1] == own_addr[BYTE_W-1:1]);
        go        = !(evt_pend && stall_en);
        done_addr = quiet && state == S_ADDR && scl_fall && bitcnt == LAST_CNT;
        rx_done   = quiet && state == S_RX && scl_fall && bitcnt == LAST_CNT;
        tx_acked  = quiet && state == S_TX_ACK && scl_rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (start_det)     nxt = S_ADDR;
        else if (stop_det) nxt = S_IDLE;
        else begin
            unique case (state)
                S_IDLE, S_WAIT: nxt = state;
                S_ADDR:     if (scl_fall && bitcnt == LAST_CNT) nxt = addr_hit ? S_ADDR_ACK : S_WAIT;
                S_ADDR_ACK: if (scl_fall) nxt = S_STALL;
                S_STALL:    if (go) nxt = dir_rd ? S_TX : S_RX;
                S_RX:       if (scl_fall && bitcnt == LAST_CNT) nxt = S_RX_ACK;
                S_RX_ACK:   if (scl_fall) nxt = S_STALL;
                S_TX:       if (scl_fall && bitcnt == TX_LAST) nxt = S_TX_ACK;
                S_TX_ACK:   if (scl_fall) nxt = host_ack ? S_STALL : S_WAIT;
                default:    nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bitcnt   <= '0;
            sda_q    <= 1'b0;
            dir_rd   <= 1'b0;
            active   <= 1'b0;
            host_ack <= 1'b0;
        end else if (start_det) begin
            bitcnt <= '0;
            sda_q  <= 1'b0;
        end else if (stop_det) begin
            bitcnt <= '0;
            sda_q  <= 1'b0;
            active <= 1'b0;
        end else begin
            unique case (state)
                S_ADDR, S_RX: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    if (scl_fall && bitcnt == LAST_CNT) begin
                        if (state == S_ADDR) begin
                            sda_q  <= addr_hit;
                            dir_rd <= shreg[0];
                            active <= addr_hit;
                        end else begin
                            sda_q <= ack_en;
                        end
                    end
                end
                S_ADDR_ACK, S_RX_ACK: if (scl_fall) begin
                    sda_q  <= 1'b0;
                    bitcnt <= '0;
                end
                S_STALL: if (go) begin
                    bitcnt <= '0;
                    if (dir_rd) begin
                        shreg <= tx_byte;
                        sda_q <= ~tx_byte[BYTE_W-1];
                    end
                end
                S_TX: if (scl_fall) begin
                    sda_q  <= (bitcnt == TX_LAST) ? 1'b0 : ~shreg[BYTE_W-2];
                    shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                    bitcnt <= bitcnt + 1'b1;
                end
                S_TX_ACK: if (scl_rise) host_ack <= ~sda_s;
                default: ;
            endcase
        end
    end

    always_comb begin
        scl_oe  = (state == S_STALL);
        sda_oe  = sda_q;
        ev_stop = stop_det && active;
        ev_cmd  = (done_addr && addr_hit) || ev_stop;
        ev_data = rx_done || tx_acked;
        ev_read = ev_stop ? 1'b0 : (done_addr ? shreg[0] : tx_acked);
        ev_ack  = tx_acked && !sda_s;
        ev_rx   = shreg;
    end

    // R6: the byte ACK drive follows the ACK-enable bit held when the byte completed
    assert_ack_choice_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == S_RX && state == S_RX_ACK) |-> (sda_q == $past(ack_en)));
    // R10: a START or STOP always leaves SDA released on the next cycle
    assert_release_on_cond_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_det || stop_det) |-> !sda_q);
    // R3: an address ACK phase is never entered while matching is disabled
    assert_no_match_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == S_ADDR && state == S_ADDR_ACK) |-> ($past(own_addr) != '0));
    // R8: while ignoring the bus, neither line is pulled
    assert_quiet_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT) |-> (!sda_q && !scl_oe));
endmodule

// File: rtl/i2c_target_stall.sv
module i2c_target_stall
    import i2ct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic [BYTE_W-1:0] own_addr,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_word,
    output logic              evt_cmd,
    output logic              evt_data,
    output logic              stat_stop,
    output logic              stat_read,
    output logic              stat_ack,
    output logic [BYTE_W-1:0] rx_byte
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic stall_en, ack_en;
    logic [BYTE_W-1:0] tx_byte, ev_rx;
    logic ev_cmd, ev_data, ev_stop, ev_read, ev_ack;

    i2ct_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det));

    i2ct_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
        .own_addr(own_addr), .evt_pend(evt_cmd | evt_data),
        .stall_en(stall_en), .ack_en(ack_en), .tx_byte(tx_byte),
        .scl_oe(scl_drive_low), .sda_oe(sda_drive_low),
        .ev_cmd(ev_cmd), .ev_data(ev_data), .ev_stop(ev_stop),
        .ev_read(ev_read), .ev_ack(ev_ack), .ev_rx(ev_rx));

    i2ct_evt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .ev_cmd(ev_cmd), .ev_data(ev_data), .ev_stop(ev_stop),
        .ev_read(ev_read), .ev_ack(ev_ack), .ev_rx(ev_rx),
        .stall_en(stall_en), .ack_en(ack_en), .tx_byte(tx_byte),
        .evt_cmd(evt_cmd), .evt_data(evt_data), .stat_stop(stat_stop),
        .stat_read(stat_read), .stat_ack(stat_ack), .rx_byte(rx_byte));

    // R4: SCL is held beyond one cycle only while an event was pending
    assert_stretch_needs_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_drive_low && $past(scl_drive_low)) |-> $past(evt_cmd || evt_data));
    // R11: SCL is held beyond one cycle only while stalling is enabled
    assert_stretch_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_drive_low && $past(scl_drive_low)) |-> $past(stall_en));
endmodule

// File: tb/tb_i2c_target_stall.sv
module tb_i2c_target_stall;
    localparam int H = 10;
    localparam int D = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_h = 1'b1, sda_h = 1'b1;
    logic [7:0] own_addr = 8'h00;
    logic cmd_wr = 1'b0;
    logic [15:0] cmd_word = 16'h0;
    logic scl_dl, sda_dl, evt_cmd, evt_data, stat_stop, stat_read, stat_ack;
    logic [7:0] rx_byte;
    wire scl_line = scl_h & ~scl_dl;
    wire sda_line = sda_h & ~sda_dl;

    always #10 clk = ~clk;

    i2c_target_stall dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_drive_low(scl_dl), .sda_drive_low(sda_dl), .own_addr(own_addr),
        .cmd_wr(cmd_wr), .cmd_word(cmd_word), .evt_cmd(evt_cmd), .evt_data(evt_data),
        .stat_stop(stat_stop), .stat_read(stat_read), .stat_ack(stat_ack), .rx_byte(rx_byte));

    int checks = 0, failures = 0, max_stretch = 0, cfg_seq = 0, cfg_done = 0;
    bit finished = 0;
    logic sw_stall = 1'b1, sw_ack = 1'b1;
    logic [12:0] exp_q[$];
    string tag_q[$];
    logic [7:0] tx_q[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [12:0] pack(input logic [1:0] kind, input logic st, input logic rd,
                                         input logic ak, input logic [7:0] rx);
        return {kind, st, rd, ak, rx};
    endfunction

    task automatic push_exp(input logic [1:0] kind, input logic st, input logic rd,
                            input logic ak, input logic [7:0] rx, input string tag);
        exp_q.push_back(pack(kind, st, rd, ak, rx));
        tag_q.push_back(tag);
    endtask

    task automatic sw_write(input logic [15:0] w);
        cmd_word = w;
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    // software responder and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (cfg_seq != cfg_done) begin
                sw_write({8'h00, 4'b0, sw_ack, 2'b0, sw_stall});
                cfg_done = cfg_seq;
            end else if (rst_n && (evt_cmd || evt_data)) begin
                logic [1:0] kind;
                logic [12:0] act;
                logic [7:0] nxt_tx;
                kind = evt_cmd ? 2'd1 : 2'd2;
                act = pack(kind, stat_stop, stat_read,
                           (kind == 2'd2 && stat_read) ? stat_ack : 1'b0,
                           (kind == 2'd2 && !stat_read) ? rx_byte : 8'h00);
                if (exp_q.size() == 0) chk(0, "unexpected event R3", {19'd0, act}, 0);
                else begin
                    logic [12:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(act == e, t, {19'd0, act}, {19'd0, e});
                end
                nxt_tx = 8'h00;
                if (stat_read && !stat_stop && (evt_cmd || stat_ack) && tx_q.size() > 0)
                    nxt_tx = tx_q.pop_front();
                wait_cyc(D);
                sw_write({nxt_tx, 8'h40 | {4'b0, sw_ack, 2'b0, sw_stall}});
            end
        end
    end

    task automatic bit_io(input logic b, output logic s, output int stretch);
        wait_cyc(2);
        sda_h = b;
        wait_cyc(H);
        scl_h = 1'b1;
        stretch = 0;
        @(negedge clk);
        while (!scl_line) begin
            stretch++;
            @(negedge clk);
        end
        if (stretch > max_stretch) max_stretch = stretch;
        wait_cyc(H / 2);
        s = sda_line;
        wait_cyc(H / 2);
        scl_h = 1'b0;
    endtask

    task automatic start_cond();
        wait_cyc(2);
        sda_h = 1'b1;
        wait_cyc(H);
        scl_h = 1'b1;
        @(negedge clk);
        while (!scl_line) @(negedge clk);
        wait_cyc(H);
        sda_h = 1'b0;
        wait_cyc(H);
        scl_h = 1'b0;
    endtask

    task automatic stop_cond();
        wait_cyc(2);
        sda_h = 1'b0;
        wait_cyc(H);
        scl_h = 1'b1;
        @(negedge clk);
        while (!scl_line) @(negedge clk);
        wait_cyc(H);
        sda_h = 1'b1;
        wait_cyc(H);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack_s, output int first_st);
        logic s;
        int st;
        first_st = 0;
        for (int i = 7; i >= 0; i--) begin
            bit_io(d[i], s, st);
            if (i == 7) first_st = st;
        end
        bit_io(1'b1, ack_s, st);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic s;
        int st;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, s, st);
            d[i] = s;
        end
        bit_io(~give_ack, s, st);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] d;
        int st;
        wait_cyc(5);
        // R1: reset state
        chk({scl_dl, sda_dl, evt_cmd, evt_data, stat_stop, stat_read, stat_ack, rx_byte} == 15'h0,
            "R1 reset", {17'd0, scl_dl, sda_dl, evt_cmd, evt_data, stat_stop, stat_read, stat_ack, rx_byte}, 0);
        rst_n = 1'b1;
        own_addr = 8'hB4;
        cfg_seq++;
        wait (cfg_done == cfg_seq);
        wait_cyc(20);

        // write transfer: ACK then NACK by command bit
        push_exp(2'd1, 0, 0, 0, 8'h00, "R2 write match event");
        start_cond();
        send_byte(8'hB4, ack, st);
        chk(ack == 1'b0, "R2 address ACK", ack, 0);
        push_exp(2'd2, 0, 0, 0, 8'hC3, "R5 received byte");
        send_byte(8'hC3, ack, st);
        chk(st > 20, "R4 stretch until clear", st, 21);
        chk(ack == 1'b0, "R6 ACK with enable set", ack, 0);
        sw_ack = 1'b0;
        push_exp(2'd2, 0, 0, 0, 8'h3C, "R5 second byte");
        send_byte(8'h3C, ack, st);
        chk(ack == 1'b1, "R6 NACK with enable clear", ack, 1);
        push_exp(2'd1, 1, 0, 0, 8'h00, "R9 stop event");
        stop_cond();
        wait_cyc(200);
        sw_ack = 1'b1;

        // read transfer ending with host NACK
        tx_q.push_back(8'hA5);
        tx_q.push_back(8'h5C);
        push_exp(2'd1, 0, 1, 0, 8'h00, "R2 read match event");
        start_cond();
        send_byte(8'hB5, ack, st);
        chk(ack == 1'b0, "R2 read address ACK", ack, 0);
        push_exp(2'd2, 0, 1, 1, 8'h00, "R8 host ACK status");
        recv_byte(1'b1, d);
        chk(d == 8'hA5, "R7 first sent byte", d, 8'hA5);
        push_exp(2'd2, 0, 1, 0, 8'h00, "R8 host NACK status");
        recv_byte(1'b0, d);
        chk(d == 8'h5C, "R7 second sent byte", d, 8'h5C);
        wait_cyc(100);
        chk(!scl_dl && !sda_dl, "R8 lines free after NACK", {scl_dl, sda_dl}, 0);
        push_exp(2'd1, 1, 0, 0, 8'h00, "R9 stop after read");
        stop_cond();
        wait_cyc(200);

        // mismatch and disabled matching
        start_cond();
        send_byte(8'h22, ack, st);
        chk(ack == 1'b1, "R3 wrong address not ACKed", ack, 1);
        send_byte(8'hFF, ack, st);
        chk(ack == 1'b1, "R3 data ignored after mismatch", ack, 1);
        stop_cond();
        wait_cyc(20);
        chk(!evt_cmd && !evt_data, "R3 no events on mismatch", {evt_cmd, evt_data}, 0);
        own_addr = 8'h00;
        start_cond();
        send_byte(8'h00, ack, st);
        chk(ack == 1'b1, "R3 zero own address disables", ack, 1);
        stop_cond();
        wait_cyc(20);
        chk(!evt_cmd && !evt_data, "R3 no events when disabled", {evt_cmd, evt_data}, 0);
        own_addr = 8'hB4;

        // repeated START inside a byte
        tx_q.push_back(8'h96);
        push_exp(2'd1, 0, 0, 0, 8'h00, "R10 first match");
        start_cond();
        send_byte(8'hB4, ack, st);
        for (int i = 0; i < 4; i++) begin
            logic s;
            bit_io(1'b0, s, st);
        end
        push_exp(2'd1, 0, 1, 0, 8'h00, "R10 match after repeated start");
        start_cond();
        send_byte(8'hB5, ack, st);
        chk(ack == 1'b0, "R10 address ACK after abort", ack, 0);
        push_exp(2'd2, 0, 1, 0, 8'h00, "R10 read after abort");
        recv_byte(1'b0, d);
        chk(d == 8'h96, "R10 byte after abort", d, 8'h96);
        wait_cyc(100);
        push_exp(2'd1, 1, 0, 0, 8'h00, "R9 stop after abort");
        stop_cond();
        wait_cyc(200);

        // stalling disabled
        sw_stall = 1'b0;
        cfg_seq++;
        wait (cfg_done == cfg_seq);
        max_stretch = 0;
        push_exp(2'd1, 0, 0, 0, 8'h00, "R11 match without stall");
        start_cond();
        send_byte(8'hB4, ack, st);
        push_exp(2'd2, 0, 0, 0, 8'h77, "R11 byte without stall");
        send_byte(8'h77, ack, st);
        chk(ack == 1'b0, "R11 byte ACKed", ack, 0);
        chk(max_stretch == 0, "R11 no stretching", max_stretch, 0);
        wait_cyc(100);
        push_exp(2'd1, 1, 0, 0, 8'h00, "R9 stop without stall");
        stop_cond();
        wait_cyc(300);
        chk(exp_q.size() == 0, "R2 all expected events seen", exp_q.size(), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule